// File: doc/BRIEF.md
# Thread-Local Memory Access Dispatcher

This block sits beside a hardware user thread and carries out its memory loads and stores. The thread presents an opcode, a byte address and, for a store, a data word, then pulses a request. The block compares the address against a private local window. A hit goes to a dual-port RAM owned by the thread. A miss becomes one single-beat transaction on a shared-bus master port, so the thread never handles a bus protocol. A finished access raises a one-cycle done pulse. A load also returns its word on the result port.

The RAM's second port is a simple bus slave. Other masters on the system bus can read and write the thread's local words through it while the thread runs. A local access finishes in two cycles. A global access takes as long as the shared bus needs, so threads should keep hot data in the window.

Top module: `tlm_dispatch`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `err`, `m_valid` and `s_rvalid` are 0 and `rdata` is 0.
- R2: An address `a` is local when `LOCAL_BASE <= a < LOCAL_BASE + LOCAL_BYTES`. It then selects word `(a - LOCAL_BASE) >> 2`, and its two low bits have no effect. Any other address is global and raises `m_valid`. A local address never raises `m_valid`.
- R3: A local load (`op` = 0) accepted at clock edge N shows the word in `rdata`, with `done` = 1, in the cycle after edge N+1.
- R4: A local store (`op` = 1) accepted at edge N writes `wdata` to the word at edge N and pulses `done` after edge N+1. A store, local or global, leaves `rdata` unchanged.
- R5: A global request accepted at edge N drives `m_valid` = 1 from edge N onward, with `m_addr`, `m_we` (1 = write) and `m_wdata` equal to the request. These stay stable until an edge samples `m_ready` = 1, and then `m_valid` drops.
- R6: A global access completes at the edge that samples `m_rsp_valid` = 1. In the following cycle `done` = 1 and `err` equals `m_rsp_err`. For a load, `rdata` equals `m_rsp_data`.
- R7: `busy` is 1 from the accepting edge until the completing edge. A `req` seen while busy has no effect on the memory, the bus or the outputs.
- R8: A slave write (`s_en` = 1, `s_we` = 1) stores `s_wdata` at word `s_idx`. A slave read (`s_en` = 1, `s_we` = 0) sampled at edge N gives `s_rvalid` = 1 and the word in `s_rdata` in the cycle after edge N. A read returns the value from before any write at that same edge.
- R9: If a user store and a slave write hit the same word at the same edge, the slave's data is kept.
- R10: `done` lasts exactly one cycle and is only high while `busy` = 0. `err` is only high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe from the user thread |
| op | input | 1 | 0 = load, 1 = store |
| addr | input | AW | Byte address |
| wdata | input | DW | Store data |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Result of the last load |
| err | output | 1 | Bus error reported with done |
| m_valid | output | 1 | Bus master request valid |
| m_we | output | 1 | Bus master write select |
| m_addr | output | AW | Bus master address |
| m_wdata | output | DW | Bus master write data |
| m_ready | input | 1 | Bus accepts the request |
| m_rsp_valid | input | 1 | Bus response valid |
| m_rsp_data | input | DW | Bus read data |
| m_rsp_err | input | 1 | Bus error response |
| s_en | input | 1 | Slave access to local RAM |
| s_we | input | 1 | Slave write select |
| s_idx | input | IDXW | Slave word index |
| s_wdata | input | DW | Slave write data |
| s_rdata | output | DW | Slave read data |
| s_rvalid | output | 1 | Slave read data valid |

## Verification
A local result is due one cycle after the accepting edge. A slave read is due one cycle after the edge that samples it. A global result is due one edge after the bus responder raises its response, and the responder's ready and response delays are set per test. A behavioural model in the bench steps once per rising edge from the same inputs and predicts every output. The bench compares that prediction against the design at each falling edge, so every result is checked in its exact cycle. Directed tasks also check, per request, whether the bus was used, along with the returned word and the error flag.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } tlm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOCAL  = 2'd1,
    ST_BUSREQ = 2'd2,
    ST_BUSRSP = 2'd3
  } tlm_state_e;

endpackage

// File: rtl/tlm_rst_sync.sv
module tlm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tlm_addr_decode.sv
module tlm_addr_decode #(
  parameter int             AW          = 32,
  parameter logic [AW-1:0]  LOCAL_BASE  = 'h0001_0000,
  parameter int             LOCAL_BYTES = 4096,
  parameter int             IDXW        = 10
) (
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [IDXW-1:0] idx
);

  logic [AW-1:0] offset;

  // offset from the window base; wraps below base, caught by the >= test
  assign offset = addr - LOCAL_BASE;
  assign hit    = (addr >= LOCAL_BASE) && (offset < AW'(LOCAL_BYTES));
  assign idx    = offset[IDXW+1:2];

endmodule

// File: rtl/tlm_dpram.sv
module tlm_dpram #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  parameter int IDXW  = 10
) (
  input  logic            clk,
  // user-side port
  input  logic            a_en,
  input  logic            a_we,
  input  logic [IDXW-1:0] a_idx,
  input  logic [DW-1:0]   a_wd,
  output logic [DW-1:0]   a_q,
  // bus-side port
  input  logic            b_en,
  input  logic            b_we,
  input  logic [IDXW-1:0] b_idx,
  input  logic [DW-1:0]   b_wd,
  output logic [DW-1:0]   b_q
);

  logic [DW-1:0] mem [DEPTH];

  // read-first on both ports; bus-side write placed last so it wins a tie
  always_ff @(posedge clk) begin
    if (a_en && !a_we) a_q <= mem[a_idx];
    if (b_en && !b_we) b_q <= mem[b_idx];
    if (a_en && a_we)  mem[a_idx] <= a_wd;
    if (b_en && b_we)  mem[b_idx] <= b_wd;
  end

endmodule

// File: rtl/tlm_ctrl.sv
module tlm_ctrl
  import tlm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IDXW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            op,
  input  logic            hit,
  input  logic [IDXW-1:0] idx,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   ram_q,
  output logic            ram_en,
  output logic            ram_we,
  output logic [IDXW-1:0] ram_idx,
  output logic [DW-1:0]   ram_wd,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic            err,
  output logic            m_valid,
  output logic            m_we,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  input  logic            m_ready,
  input  logic            m_rsp_valid,
  input  logic [DW-1:0]   m_rsp_data,
  input  logic            m_rsp_err
);

  tlm_state_e    state_q, state_d;
  tlm_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          take, rd_en;

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    rd_en   = 1'b0;
    rdata_d = rdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          take    = 1'b1;
          state_d = hit ? ST_LOCAL : ST_BUSREQ;
        end
      end
      ST_LOCAL: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        if (op_q == OP_LOAD) begin
          rd_en   = 1'b1;
          rdata_d = ram_q;
        end
      end
      ST_BUSREQ: begin
        if (m_ready) state_d = ST_BUSRSP;
      end
      ST_BUSRSP: begin
        if (m_rsp_valid) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = m_rsp_err;
          if (op_q == OP_LOAD) begin
            rd_en   = 1'b1;
            rdata_d = m_rsp_data;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  // request capture, no reset needed: only read after a take
  always_ff @(posedge clk) begin
    if (take) begin
      op_q    <= tlm_op_e'(op);
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  assign ram_en  = (state_q == ST_IDLE) && req && hit;
  assign ram_we  = (tlm_op_e'(op) == OP_STORE);
  assign ram_idx = idx;
  assign ram_wd  = wdata;

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign rdata   = rdata_q;
  assign m_valid = (state_q == ST_BUSREQ);
  assign m_we    = (op_q == OP_STORE);
  assign m_addr  = addr_q;
  assign m_wdata = wdata_q;

endmodule

// File: rtl/tlm_dispatch.sv
module tlm_dispatch
  import tlm_pkg::*;
#(
  parameter int            AW          = 32,
  parameter int            DW          = 32,
  parameter logic [AW-1:0] LOCAL_BASE  = 'h0001_0000,
  parameter int            LOCAL_BYTES = 4096,
  localparam int           IDXW        = $clog2(LOCAL_BYTES / 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            op,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic            err,
  output logic            m_valid,
  output logic            m_we,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  input  logic            m_ready,
  input  logic            m_rsp_valid,
  input  logic [DW-1:0]   m_rsp_data,
  input  logic            m_rsp_err,
  input  logic            s_en,
  input  logic            s_we,
  input  logic [IDXW-1:0] s_idx,
  input  logic [DW-1:0]   s_wdata,
  output logic [DW-1:0]   s_rdata,
  output logic            s_rvalid
);

  localparam int DEPTH = LOCAL_BYTES / 4;

  logic            rst_sync_n;
  logic            hit;
  logic [IDXW-1:0] idx;
  logic            ram_en, ram_we;
  logic [IDXW-1:0] ram_idx;
  logic [DW-1:0]   ram_wd, ram_q;
  logic            s_rvalid_q;

  tlm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tlm_addr_decode #(
    .AW(AW), .LOCAL_BASE(LOCAL_BASE), .LOCAL_BYTES(LOCAL_BYTES), .IDXW(IDXW)
  ) u_dec (
    .addr (addr),
    .hit  (hit),
    .idx  (idx)
  );

  tlm_dpram #(.DW(DW), .DEPTH(DEPTH), .IDXW(IDXW)) u_ram (
    .clk   (clk),
    .a_en  (ram_en),
    .a_we  (ram_we),
    .a_idx (ram_idx),
    .a_wd  (ram_wd),
    .a_q   (ram_q),
    .b_en  (s_en),
    .b_we  (s_we),
    .b_idx (s_idx),
    .b_wd  (s_wdata),
    .b_q   (s_rdata)
  );

  tlm_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req         (req),
    .op          (op),
    .hit         (hit),
    .idx         (idx),
    .addr        (addr),
    .wdata       (wdata),
    .ram_q       (ram_q),
    .ram_en      (ram_en),
    .ram_we      (ram_we),
    .ram_idx     (ram_idx),
    .ram_wd      (ram_wd),
    .busy        (busy),
    .done        (done),
    .rdata       (rdata),
    .err         (err),
    .m_valid     (m_valid),
    .m_we        (m_we),
    .m_addr      (m_addr),
    .m_wdata     (m_wdata),
    .m_ready     (m_ready),
    .m_rsp_valid (m_rsp_valid),
    .m_rsp_data  (m_rsp_data),
    .m_rsp_err   (m_rsp_err)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s_rvalid_q <= 1'b0;
    else             s_rvalid_q <= s_en && !s_we;
  end

  assign s_rvalid = s_rvalid_q;

endmodule

// File: rtl/tlm_dispatch_chk.sv
module tlm_dispatch_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [DW-1:0] m_wdata,
  input logic          s_en,
  input logic          s_we,
  input logic          s_rvalid
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  // R5
  bus_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> busy);

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> busy);

  // R8
  slave_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && !s_we) |=> s_rvalid);

endmodule

bind tlm_dispatch tlm_dispatch_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req      (req),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_we     (m_we),
  .m_addr   (m_addr),
  .m_wdata  (m_wdata),
  .s_en     (s_en),
  .s_we     (s_we),
  .s_rvalid (s_rvalid)
);

// File: tb/tlm_dispatch_tb_top.sv
module tlm_dispatch_tb_top;

  localparam logic [31:0] BASE  = 32'h0001_0000;
  localparam int          BYTES = 4096;
  localparam int          WORDS = BYTES / 4;
  localparam logic [31:0] KEY   = 32'h5A5A_A5A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, op = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        m_valid, m_we;
  logic [31:0] m_addr, m_wdata;
  logic        m_ready = 1'b0, m_rsp_valid = 1'b0, m_rsp_err = 1'b0;
  logic [31:0] m_rsp_data = '0;
  logic        s_en = 1'b0, s_we = 1'b0;
  logic [9:0]  s_idx = '0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic        s_rvalid;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tlm_dispatch #(.AW(32), .DW(32), .LOCAL_BASE(BASE), .LOCAL_BYTES(BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .err(err),
    .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rsp_valid(m_rsp_valid), .m_rsp_data(m_rsp_data),
    .m_rsp_err(m_rsp_err), .s_en(s_en), .s_we(s_we), .s_idx(s_idx),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .s_rvalid(s_rvalid)
  );

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic bit is_local(input logic [31:0] a);
    return (a >= BASE) && ((a - BASE) < BYTES);
  endfunction

  function automatic int word_of(input logic [31:0] a);
    return int'((a - BASE) >> 2);
  endfunction

  // ---------------- behavioural reference model ----------------
  int          mst;
  logic        mop;
  logic [31:0] mq;
  logic [31:0] mmem [WORDS];
  logic        e_done, e_err, e_srv;
  logic [31:0] e_rdata, e_srd, e_maddr, e_mwd;
  logic        e_mwe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; e_done = 0; e_err = 0; e_rdata = '0; e_srv = 0;
    end else begin
      logic n_done, n_err, uwr;
      int   uidx;
      n_done = 0; n_err = 0; uwr = 0; uidx = 0;
      e_srv = s_en && !s_we;
      if (e_srv) e_srd = mmem[s_idx];
      case (mst)
        0: if (req) begin
             mop = op; e_maddr = addr; e_mwd = wdata; e_mwe = op;
             if (is_local(addr)) begin
               mst = 1; uidx = word_of(addr);
               if (op) uwr = 1; else mq = mmem[uidx];
             end else mst = 2;
           end
        1: begin n_done = 1; if (!mop) e_rdata = mq; mst = 0; end
        2: if (m_ready) mst = 3;
        3: if (m_rsp_valid) begin
             n_done = 1; n_err = m_rsp_err;
             if (!mop) e_rdata = m_rsp_data;
             mst = 0;
           end
        default: mst = 0;
      endcase
      if (uwr) mmem[uidx] = wdata;
      if (s_en && s_we) mmem[s_idx] = s_wdata;
      e_done = n_done; e_err = n_err;
    end
  end

  // per-cycle comparison away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10", "done",    {31'd0, done},    {31'd0, e_done});
      chk("R6",  "err",     {31'd0, err},     {31'd0, e_err});
      chk("R3",  "rdata",   rdata,            e_rdata);
      chk("R7",  "busy",    {31'd0, busy},    {31'd0, mst != 0});
      chk("R5",  "m_valid", {31'd0, m_valid}, {31'd0, mst == 2});
      chk("R8",  "s_rvalid",{31'd0, s_rvalid},{31'd0, e_srv});
      if (e_srv) chk("R8", "s_rdata", s_rdata, e_srd);
      if (mst == 2) begin
        chk("R5", "m_addr",  m_addr,  e_maddr);
        chk("R5", "m_we",    {31'd0, m_we}, {31'd0, e_mwe});
        chk("R5", "m_wdata", m_wdata, e_mwd);
      end
    end
  end

  // ---------------- bus responder ----------------
  int          rdy_lat = 0, rsp_lat = 0;
  bit          err_next = 0;
  int          bst = 0, bcnt = 0;
  logic [31:0] hold_addr;

  always @(negedge clk) begin
    if (!rst_n) begin
      bst = 0; bcnt = 0; m_ready = 0; m_rsp_valid = 0; m_rsp_err = 0;
    end else begin
      case (bst)
        0: if (m_valid) begin
             if (bcnt >= rdy_lat) begin
               m_ready = 1; hold_addr = m_addr; bst = 1; bcnt = 0;
             end else bcnt++;
           end
        1: begin
             m_ready = 0;
             if (bcnt >= rsp_lat) begin
               m_rsp_valid = 1; m_rsp_data = hold_addr ^ KEY; m_rsp_err = err_next;
               bst = 2; bcnt = 0;
             end else bcnt++;
           end
        default: begin m_rsp_valid = 0; m_rsp_err = 0; bst = 0; end
      endcase
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog act=%0d exp=<50000", cyc);
      report();
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wait_done(output bit saw_bus);
    int guard = 0;
    saw_bus = 0;
    while (!done && guard < 1000) begin
      if (m_valid) saw_bus = 1;
      @(negedge clk); guard++;
    end
  endtask

  task automatic uop(input logic o, input logic [31:0] a, input logic [31:0] d,
                     input bit exp_bus, input bit chk_rd, input logic [31:0] exp_rd,
                     input bit exp_err, input string r);
    bit saw;
    @(negedge clk); req = 1; op = o; addr = a; wdata = d;
    @(negedge clk); req = 0;
    wait_done(saw);
    chk(r, "bus_used", {31'd0, saw}, {31'd0, exp_bus});
    chk(r, "done_err", {31'd0, err}, {31'd0, exp_err});
    if (chk_rd) chk(r, "result", rdata, exp_rd);
  endtask

  task automatic swr(input int i, input logic [31:0] d);
    @(negedge clk); s_en = 1; s_we = 1; s_idx = 10'(i); s_wdata = d;
    @(negedge clk); s_en = 0; s_we = 0;
  endtask

  task automatic srd(input int i, input logic [31:0] exp, input string r);
    @(negedge clk); s_en = 1; s_we = 0; s_idx = 10'(i);
    @(negedge clk); s_en = 0;
    chk(r, "slave_rvalid", {31'd0, s_rvalid}, 32'd1);
    chk(r, "slave_rdata", s_rdata, exp);
  endtask

  initial begin
    bit saw;
    repeat (3) @(negedge clk);
    // R1: values under reset
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "err", {31'd0, err}, 32'd0);
    chk("R1", "m_valid", {31'd0, m_valid}, 32'd0);
    chk("R1", "s_rvalid", {31'd0, s_rvalid}, 32'd0);
    chk("R1", "rdata", rdata, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "busy_after", {31'd0, busy}, 32'd0);

    // R4: local stores, rdata untouched
    uop(1, BASE + 32'h0,   32'h1111_0000, 0, 1, 32'd0, 0, "R4");
    uop(1, BASE + 32'hFFC, 32'h2222_FFFF, 0, 1, 32'd0, 0, "R2");
    // R3: local loads
    uop(0, BASE + 32'h0,   32'h0, 0, 1, 32'h1111_0000, 0, "R3");
    uop(0, BASE + 32'hFFE, 32'h0, 0, 1, 32'h2222_FFFF, 0, "R2");
    uop(1, BASE + 32'h8,   32'h0000_0033, 0, 1, 32'h2222_FFFF, 0, "R4");
    uop(0, BASE + 32'h9,   32'h0, 0, 1, 32'h0000_0033, 0, "R2");

    // R2/R6: just past the window and just below it go to the bus
    rdy_lat = 0; rsp_lat = 0;
    uop(0, BASE + BYTES, 32'h0, 1, 1, (BASE + BYTES) ^ KEY, 0, "R6");
    rdy_lat = 3; rsp_lat = 2;
    uop(0, BASE - 4, 32'h0, 1, 1, (BASE - 4) ^ KEY, 0, "R2");
    rdy_lat = 1; rsp_lat = 1;
    uop(1, 32'h8000_0000, 32'hCAFE_0001, 1, 1, (BASE - 4) ^ KEY, 0, "R5");
    // R6: error response
    err_next = 1;
    uop(0, 32'hE000_0010, 32'h0, 1, 1, 32'hE000_0010 ^ KEY, 1, "R6");
    err_next = 0;

    // R8: slave port both ways
    swr(7, 32'h7777_0007);
    uop(0, BASE + 32'h1C, 32'h0, 0, 1, 32'h7777_0007, 0, "R8");
    srd(0, 32'h1111_0000, "R8");

    // R7: request while busy is ignored
    uop(1, BASE + 32'h40, 32'h0000_4040, 0, 0, 32'd0, 0, "R7");
    rdy_lat = 5; rsp_lat = 3;
    @(negedge clk); req = 1; op = 0; addr = 32'h9000_0000; wdata = '0;
    @(negedge clk); req = 0;
    @(negedge clk); req = 1; op = 1; addr = BASE + 32'h40; wdata = 32'hDEAD_BEEF;
    @(negedge clk); req = 0;
    wait_done(saw);
    chk("R7", "result", rdata, 32'h9000_0000 ^ KEY);
    srd(16, 32'h0000_4040, "R7");

    // R9: same-edge collision, slave data kept
    @(negedge clk);
    req = 1; op = 1; addr = BASE + 32'h14; wdata = 32'hAAAA_AAAA;
    s_en = 1; s_we = 1; s_idx = 10'd5; s_wdata = 32'hBBBB_BBBB;
    @(negedge clk); req = 0; s_en = 0; s_we = 0;
    wait_done(saw);
    srd(5, 32'hBBBB_BBBB, "R9");
    uop(0, BASE + 32'h14, 32'h0, 0, 1, 32'hBBBB_BBBB, 0, "R9");

    // R3: back-to-back local traffic
    for (int i = 0; i < 8; i++)
      uop(1, BASE + 32'h100 + 32'(i * 4), 32'hC0DE_0000 + 32'(i), 0, 0, 32'd0, 0, "R4");
    for (int i = 7; i >= 0; i--)
      uop(0, BASE + 32'h100 + 32'(i * 4), 32'h0, 0, 1, 32'hC0DE_0000 + 32'(i), 0, "R3");

    repeat (4) @(negedge clk);
    report();
  end

endmodule